// File: doc/BRIEF.md
# Flow-Control Status Receiver with Port Calendar

This block sits on the return path of a packet link. Each clock it takes one 2-bit flow-control status word from the far end. It finds the frame boundaries, checks a 2-bit parity word at the end of every frame, and works out which logical port each status slot belongs to by walking a programmable calendar of port numbers. Port updates come out as a valid-strobed stream of (port, status) pairs. They are released only from frames whose parity is correct. A level output tells whether the receiver is framed, and a one-cycle pulse flags each rejected frame.

Two calendar banks exist. One is live and one is the shadow. Software fills the shadow through a write port and then requests a swap. The swap is applied at the next framing word, so a frame never mixes entries from the two banks.

The update stream has no ready input. The incoming status words cannot be stalled, so a downstream consumer must accept one update in every cycle that `upd_valid` is high. Updates from one frame come out in consecutive cycles. They finish before the next frame's updates can begin.

Top module: `scr_status_rx`

## Requirements
- R1: After reset, `sync_ok`, `upd_valid` and `frame_bad` are low, and both calendar banks map entry i to port i.
- R2: A frame is: a framing word 2'b11, then `cfg_cal_len` × `cfg_cal_rep` status slots, then one parity word. The length and repetition settings (each at least 1) are taken when the framing word arrives. While waiting for a framing word, any other word is ignored.
- R3: The expected parity word is 2'b11 XOR the bitwise XOR of all slot words of the frame. On a mismatch, `frame_bad` pulses for one cycle starting the cycle after the parity word, and no update from that frame is released.
- R4: A slot word equal to 2'b11 makes the whole frame bad, even if the parity word matches.
- R5: A good frame received while framed is released as updates in slot order, one per cycle, starting two cycles after its parity word.
- R6: Slot k is assigned the port in calendar entry (k mod `cfg_cal_len`), so the calendar repeats `cfg_cal_rep` times within a frame.
- R7: While framed, `cfg_loss_n` consecutive bad frames drop `sync_ok` at the same edge as the last one. A good frame clears the count of bad frames.
- R8: While not framed, `cfg_lock_n` consecutive good frames raise `sync_ok`, and the frame that completes the lock is released. Earlier frames in the run are not released.
- R9: Calendar writes go only to the shadow bank and do not change the ports assigned to frames before the swap.
- R10: A swap request takes effect at the next framing word. The frame in progress keeps the old mapping, and the next frame uses the new bank.
- R11: `upd_stat` carries the received code unchanged: 2'b00 starving, 2'b01 hungry, 2'b10 satisfied. It is never 2'b11 while valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_in | input | 2 | Incoming status word, one per cycle |
| cfg_cal_len | input | LEN_W | Calendar entries used per round (1..CAL_DEPTH) |
| cfg_cal_rep | input | REP_W | Calendar rounds per frame (1..MAX_REP) |
| cfg_loss_n | input | CNT_W | Consecutive bad frames that drop framing (>=1) |
| cfg_lock_n | input | CNT_W | Consecutive good frames that gain framing (>=1) |
| shd_wr_en | input | 1 | Write strobe for the shadow calendar |
| shd_wr_idx | input | IDX_W | Shadow calendar entry to write |
| shd_wr_port | input | PORT_W | Port number to store |
| swap_req | input | 1 | Request to make the shadow bank live |
| upd_valid | output | 1 | Port update present this cycle |
| upd_port | output | PORT_W | Logical port of the update |
| upd_stat | output | 2 | Status code of the update |
| sync_ok | output | 1 | Receiver is framed |
| frame_bad | output | 1 | One-cycle pulse per rejected frame |

## Verification
The bench targets four behaviours, each with a distinct failure:
- Release gating: a receiver that leaks updates before lock, or from a frame with bad parity, shows extra entries in the update log.
- Reserved slot code: if a 2'b11 slot is not caught, a reserved-code frame with matching parity is released.
- Bad-frame counter: the bench sends bad, good, bad, bad. If a good frame does not clear the counter, framing is lost too early. An off-by-one threshold loses it too late or not at all.
- Calendar swap: the swap is requested mid-frame. Applying it at once shows the new ports in the current frame, and sending writes to the live bank changes ports before the swap.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic [1:0] {
    ST_STARVING  = 2'b00,
    ST_HUNGRY    = 2'b01,
    ST_SATISFIED = 2'b10,
    ST_FRAME     = 2'b11
  } stat_code_e;
endpackage

// File: rtl/scr_cal.sv
module scr_cal #(
  parameter int PORT_W    = 8,
  parameter int CAL_DEPTH = 16,
  localparam int IDX_W    = $clog2(CAL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PORT_W-1:0] wr_port,
  input  logic              swap_req,
  input  logic              frame_start,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PORT_W-1:0] rd_port
);
  logic [PORT_W-1:0] bank_q [2][CAL_DEPTH];
  logic              live_q;
  logic              pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < CAL_DEPTH; i++)
          bank_q[b][i] <= PORT_W'(i);
    end else if (wr_en) begin
      bank_q[~live_q][wr_idx] <= wr_port;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (frame_start && (pend_q || swap_req)) begin
      live_q <= ~live_q;
      pend_q <= 1'b0;
    end else if (swap_req) begin
      pend_q <= 1'b1;
    end
  end

  assign rd_port = bank_q[live_q][rd_idx];
endmodule

// File: rtl/scr_framer.sv
module scr_framer
  import scr_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int CAL_DEPTH = 16,
  parameter int MAX_REP   = 4,
  parameter int CNT_W     = 4,
  localparam int LEN_W    = $clog2(CAL_DEPTH + 1),
  localparam int IDX_W    = $clog2(CAL_DEPTH),
  localparam int REP_W    = $clog2(MAX_REP + 1),
  localparam int SLOTS    = CAL_DEPTH * MAX_REP,
  localparam int SIDX_W   = $clog2(SLOTS),
  localparam int POS_W    = $clog2(SLOTS + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          stat_in,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [REP_W-1:0]    cfg_rep,
  input  logic [CNT_W-1:0]    cfg_loss,
  input  logic [CNT_W-1:0]    cfg_lock,
  input  logic [PORT_W-1:0]   cal_port,
  output logic                frame_start,
  output logic [IDX_W-1:0]    cal_idx,
  output logic                slot_we,
  output logic [SIDX_W-1:0]   slot_addr,
  output logic [PORT_W+1:0]   slot_word,
  output logic                rel_start,
  output logic [POS_W-1:0]    rel_cnt,
  output logic                sync_ok,
  output logic                frame_bad
);
  logic [POS_W-1:0]       pos_q, total_q;
  logic [LEN_W-1:0]       len_q;
  logic [1:0]             par_q;
  logic                   resv_q;
  logic [CNT_W-1:0]       bad_q, good_q;
  logic [LEN_W+REP_W-1:0] prod;
  logic [CNT_W:0]         bad_inc, good_inc;
  logic                   in_slot, at_dip, dip_ok, ev_good, ev_bad;

  assign prod        = {{REP_W{1'b0}}, cfg_len} * {{LEN_W{1'b0}}, cfg_rep};
  assign frame_start = (pos_q == '0) && (stat_in == ST_FRAME);
  assign in_slot     = (pos_q != '0) && (pos_q <= total_q);
  assign at_dip      = (pos_q != '0) && (pos_q == total_q + POS_W'(1));
  assign dip_ok      = !resv_q && (stat_in == (par_q ^ 2'b11));
  assign ev_good     = at_dip && dip_ok;
  assign ev_bad      = at_dip && !dip_ok;
  assign bad_inc     = {1'b0, bad_q} + (CNT_W+1)'(1);
  assign good_inc    = {1'b0, good_q} + (CNT_W+1)'(1);

  assign slot_we   = in_slot;
  assign slot_addr = SIDX_W'(pos_q - POS_W'(1));
  assign slot_word = {cal_port, stat_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q     <= '0;
      total_q   <= '0;
      len_q     <= '0;
      par_q     <= '0;
      resv_q    <= 1'b0;
      cal_idx   <= '0;
      bad_q     <= '0;
      good_q    <= '0;
      sync_ok   <= 1'b0;
      rel_start <= 1'b0;
      rel_cnt   <= '0;
      frame_bad <= 1'b0;
    end else begin
      rel_start <= 1'b0;
      frame_bad <= 1'b0;
      if (frame_start) begin
        pos_q   <= POS_W'(1);
        len_q   <= cfg_len;
        total_q <= POS_W'(prod);
        cal_idx <= '0;
        par_q   <= '0;
        resv_q  <= 1'b0;
      end else if (in_slot) begin
        pos_q   <= pos_q + POS_W'(1);
        par_q   <= par_q ^ stat_in;
        if (stat_in == ST_FRAME) resv_q <= 1'b1;
        cal_idx <= (cal_idx == IDX_W'(len_q - LEN_W'(1))) ? '0 : cal_idx + IDX_W'(1);
      end else if (at_dip) begin
        pos_q <= '0;
      end

      if (ev_bad) begin
        frame_bad <= 1'b1;
        good_q    <= '0;
        if (sync_ok) begin
          if (bad_inc >= {1'b0, cfg_loss}) begin
            sync_ok <= 1'b0;
            bad_q   <= '0;
          end else begin
            bad_q <= bad_inc[CNT_W-1:0];
          end
        end
      end

      if (ev_good) begin
        bad_q   <= '0;
        rel_cnt <= total_q;
        if (sync_ok) begin
          rel_start <= 1'b1;
        end else if (good_inc >= {1'b0, cfg_lock}) begin
          sync_ok   <= 1'b1;
          good_q    <= '0;
          rel_start <= 1'b1;
        end else begin
          good_q <= good_inc[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/scr_replay.sv
module scr_replay #(
  parameter int WORD_W  = 10,
  parameter int SLOTS   = 64,
  localparam int SIDX_W = $clog2(SLOTS),
  localparam int POS_W  = $clog2(SLOTS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SIDX_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rel_start,
  input  logic [POS_W-1:0]  rel_cnt,
  output logic              upd_valid,
  output logic [WORD_W-1:0] upd_word
);
  logic [WORD_W-1:0] mem_q [SLOTS];
  logic [SIDX_W-1:0] rd_q, last_q;
  logic              act_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rd_q   <= '0;
      last_q <= '0;
    end else if (rel_start) begin
      act_q  <= 1'b1;
      rd_q   <= '0;
      last_q <= SIDX_W'(rel_cnt - POS_W'(1));
    end else if (act_q) begin
      if (rd_q == last_q) act_q <= 1'b0;
      else                rd_q  <= rd_q + SIDX_W'(1);
    end
  end

  assign upd_valid = act_q;
  assign upd_word  = mem_q[rd_q];
endmodule

// File: rtl/scr_status_rx.sv
module scr_status_rx #(
  parameter int PORT_W    = 8,
  parameter int CAL_DEPTH = 16,
  parameter int MAX_REP   = 4,
  parameter int CNT_W     = 4,
  localparam int LEN_W    = $clog2(CAL_DEPTH + 1),
  localparam int IDX_W    = $clog2(CAL_DEPTH),
  localparam int REP_W    = $clog2(MAX_REP + 1),
  localparam int SLOTS    = CAL_DEPTH * MAX_REP,
  localparam int SIDX_W   = $clog2(SLOTS),
  localparam int POS_W    = $clog2(SLOTS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        stat_in,
  input  logic [LEN_W-1:0]  cfg_cal_len,
  input  logic [REP_W-1:0]  cfg_cal_rep,
  input  logic [CNT_W-1:0]  cfg_loss_n,
  input  logic [CNT_W-1:0]  cfg_lock_n,
  input  logic              shd_wr_en,
  input  logic [IDX_W-1:0]  shd_wr_idx,
  input  logic [PORT_W-1:0] shd_wr_port,
  input  logic              swap_req,
  output logic              upd_valid,
  output logic [PORT_W-1:0] upd_port,
  output logic [1:0]        upd_stat,
  output logic              sync_ok,
  output logic              frame_bad
);
  logic              frame_start, slot_we, rel_start;
  logic [IDX_W-1:0]  cal_idx;
  logic [PORT_W-1:0] cal_port;
  logic [SIDX_W-1:0] slot_addr;
  logic [PORT_W+1:0] slot_word, upd_word;
  logic [POS_W-1:0]  rel_cnt;

  scr_cal #(.PORT_W(PORT_W), .CAL_DEPTH(CAL_DEPTH)) cal_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(shd_wr_en), .wr_idx(shd_wr_idx), .wr_port(shd_wr_port),
    .swap_req(swap_req), .frame_start(frame_start),
    .rd_idx(cal_idx), .rd_port(cal_port)
  );

  scr_framer #(.PORT_W(PORT_W), .CAL_DEPTH(CAL_DEPTH), .MAX_REP(MAX_REP), .CNT_W(CNT_W)) frm_i (
    .clk(clk), .rst_n(rst_n), .stat_in(stat_in),
    .cfg_len(cfg_cal_len), .cfg_rep(cfg_cal_rep),
    .cfg_loss(cfg_loss_n), .cfg_lock(cfg_lock_n),
    .cal_port(cal_port), .frame_start(frame_start), .cal_idx(cal_idx),
    .slot_we(slot_we), .slot_addr(slot_addr), .slot_word(slot_word),
    .rel_start(rel_start), .rel_cnt(rel_cnt),
    .sync_ok(sync_ok), .frame_bad(frame_bad)
  );

  scr_replay #(.WORD_W(PORT_W + 2), .SLOTS(SLOTS)) rep_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(slot_we), .wr_addr(slot_addr), .wr_word(slot_word),
    .rel_start(rel_start), .rel_cnt(rel_cnt),
    .upd_valid(upd_valid), .upd_word(upd_word)
  );

  assign upd_port = upd_word[PORT_W+1:2];
  assign upd_stat = upd_word[1:0];
endmodule

// File: rtl/scr_status_rx_chk.sv
module scr_status_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_valid,
  input logic [1:0] upd_stat,
  input logic       sync_ok,
  input logic       frame_bad
);
  assert_stat_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> upd_stat != 2'b11);

  assert_loss_on_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_ok) |-> frame_bad);

  assert_lock_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> !frame_bad);

  assert_lock_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |=> upd_valid);

  assert_release_framed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_valid) |-> $past(sync_ok));
endmodule

bind scr_status_rx scr_status_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_stat(upd_stat),
  .sync_ok(sync_ok), .frame_bad(frame_bad)
);

// File: tb/scr_status_rx_tb.sv
module scr_status_rx_tb_top;
  localparam int PORT_W = 8;
  localparam int CAL_DEPTH = 16;
  localparam int MAX_REP = 4;
  localparam int CNT_W = 4;
  localparam int IDLE = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] stat_in = 2'b00;
  logic [4:0] cfg_cal_len = 5'd4;
  logic [2:0] cfg_cal_rep = 3'd1;
  logic [CNT_W-1:0] cfg_loss_n = 4'd2;
  logic [CNT_W-1:0] cfg_lock_n = 4'd2;
  logic shd_wr_en = 1'b0;
  logic [3:0] shd_wr_idx = '0;
  logic [PORT_W-1:0] shd_wr_port = '0;
  logic swap_req = 1'b0;
  logic upd_valid, sync_ok, frame_bad;
  logic [PORT_W-1:0] upd_port;
  logic [1:0] upd_stat;

  int n_chk = 0, n_fail = 0, log_n = 0, bad_n = 0;
  int log_port [64];
  int log_stat [64];
  logic [1:0] fr [64];
  bit done = 0;

  always #10 clk = ~clk;

  scr_status_rx #(.PORT_W(PORT_W), .CAL_DEPTH(CAL_DEPTH), .MAX_REP(MAX_REP), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .stat_in(stat_in),
    .cfg_cal_len(cfg_cal_len), .cfg_cal_rep(cfg_cal_rep),
    .cfg_loss_n(cfg_loss_n), .cfg_lock_n(cfg_lock_n),
    .shd_wr_en(shd_wr_en), .shd_wr_idx(shd_wr_idx), .shd_wr_port(shd_wr_port),
    .swap_req(swap_req), .upd_valid(upd_valid), .upd_port(upd_port),
    .upd_stat(upd_stat), .sync_ok(sync_ok), .frame_bad(frame_bad)
  );

  always @(negedge clk) if (rst_n) begin
    if (upd_valid && log_n < 64) begin
      log_port[log_n] = int'(upd_port);
      log_stat[log_n] = int'(upd_stat);
      log_n++;
    end
    if (frame_bad) bad_n++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    log_n = 0;
    bad_n = 0;
  endtask

  task automatic idle();
    repeat (IDLE) @(negedge clk) stat_in = 2'b00;
  endtask

  // frame of n slots from fr[], parity optionally corrupted
  task automatic send_frame(input int n, input bit corrupt);
    logic [1:0] p = 2'b00;
    @(negedge clk) stat_in = 2'b11;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) stat_in = fr[i];
      p = p ^ fr[i];
    end
    @(negedge clk) stat_in = p ^ 2'b11 ^ (corrupt ? 2'b01 : 2'b00);
  endtask

  task automatic cal_write(input int idx, input int port);
    @(negedge clk);
    shd_wr_en = 1'b1; shd_wr_idx = 4'(idx); shd_wr_port = PORT_W'(port);
    @(negedge clk) shd_wr_en = 1'b0;
  endtask

  task automatic check_log(input string req, input int n, input int base_port, input int plen);
    check(log_n == n, req, log_n, n);
    for (int i = 0; i < n && i < log_n; i++) begin
      check(log_port[i] == base_port + (i % plen), req, log_port[i], base_port + (i % plen));
      check(log_stat[i] == int'(fr[i]), req, log_stat[i], int'(fr[i]));
    end
  endtask

  task automatic t_reset();
    check(sync_ok == 1'b0, "R1 sync_ok", int'(sync_ok), 0);
    check(upd_valid == 1'b0, "R1 upd_valid", int'(upd_valid), 0);
    check(frame_bad == 1'b0, "R1 frame_bad", int'(frame_bad), 0);
  endtask

  task automatic t_lock();
    clear_log();
    fr[0] = 2'd0; fr[1] = 2'd1; fr[2] = 2'd2; fr[3] = 2'd0;
    send_frame(4, 0); idle();
    check(sync_ok == 1'b0, "R8 one good frame not locked", int'(sync_ok), 0);
    check(log_n == 0, "R8 pre-lock frame held", log_n, 0);
    clear_log();
    fr[0] = 2'd2; fr[1] = 2'd1; fr[2] = 2'd0; fr[3] = 2'd1;
    send_frame(4, 0); idle();
    check(sync_ok == 1'b1, "R8 locked", int'(sync_ok), 1);
    check_log("R5 R1 R11 lock frame release", 4, 0, 4);
  endtask

  task automatic t_repeat();
    clear_log();
    cfg_cal_len = 5'd3; cfg_cal_rep = 3'd2;
    fr[0] = 2'd1; fr[1] = 2'd0; fr[2] = 2'd2; fr[3] = 2'd2; fr[4] = 2'd1; fr[5] = 2'd0;
    send_frame(6, 0); idle();
    check_log("R6 R2 calendar repeated", 6, 0, 3);
    cfg_cal_len = 5'd4; cfg_cal_rep = 3'd1;
  endtask

  task automatic t_loss();
    fr[0] = 2'd1; fr[1] = 2'd1; fr[2] = 2'd0; fr[3] = 2'd2;
    clear_log();
    send_frame(4, 1); idle();
    check(log_n == 0, "R3 bad parity held", log_n, 0);
    check(bad_n == 1, "R3 frame_bad pulse", bad_n, 1);
    check(sync_ok == 1'b1, "R7 one bad keeps sync", int'(sync_ok), 1);
    clear_log();
    send_frame(4, 0); idle();
    check(log_n == 4, "R7 good frame between bad", log_n, 4);
    send_frame(4, 1); idle();
    check(sync_ok == 1'b1, "R7 count cleared by good", int'(sync_ok), 1);
    send_frame(4, 1); idle();
    check(sync_ok == 1'b0, "R7 framing lost", int'(sync_ok), 0);
    clear_log();
    send_frame(4, 0); idle();
    check(log_n == 0 && sync_ok == 1'b0, "R8 relock first frame held", log_n, 0);
    send_frame(4, 0); idle();
    check(sync_ok == 1'b1, "R8 relocked", int'(sync_ok), 1);
    check(log_n == 4, "R8 relock frame released", log_n, 4);
  endtask

  task automatic t_reserved();
    clear_log();
    fr[0] = 2'd0; fr[1] = 2'd3; fr[2] = 2'd1; fr[3] = 2'd2;
    send_frame(4, 0); idle();
    check(log_n == 0, "R4 reserved slot held", log_n, 0);
    check(bad_n == 1, "R4 reserved slot flagged", bad_n, 1);
    fr[1] = 2'd1;
    clear_log();
    send_frame(4, 0); idle();
    check(log_n == 4, "R4 recovery after reserved", log_n, 4);
  endtask

  task automatic t_swap();
    for (int i = 0; i < 4; i++) cal_write(i, 200 + i);
    fr[0] = 2'd2; fr[1] = 2'd0; fr[2] = 2'd1; fr[3] = 2'd1;
    clear_log();
    send_frame(4, 0); idle();
    check_log("R9 shadow write isolated", 4, 0, 4);
    clear_log();
    fork
      send_frame(4, 0);
      begin
        repeat (3) @(negedge clk);
        swap_req = 1'b1;
        @(negedge clk) swap_req = 1'b0;
      end
    join
    idle();
    check_log("R10 frame in progress keeps map", 4, 0, 4);
    clear_log();
    send_frame(4, 0); idle();
    check_log("R10 next frame uses new bank", 4, 200, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    idle();
    t_lock();
    t_repeat();
    t_loss();
    t_reserved();
    t_swap();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule